// File: doc/BRIEF.md
# Inter-Processor Mailbox Channel Controller

This peripheral lets a local processor hand short fixed-length messages to a remote processor and learn when the remote side has taken them. It sits on a simple register bus with an address, a write strobe, write data and combinational read data. It holds a parameterised number of channels, up to 32. Each channel has a 64-byte register window with eight message words, its vector selections, an interrupt mask and a small ownership state machine. Interrupt outputs are one line per vector. Each line is the OR of every channel's contribution.

A key-protected lock guards every channel register. After reset the block is locked. Writing the key word to the lock register opens it. Writing any other word closes it again. A sender claims an idle channel by writing its one-hot vector to the owner register. It then fills the message words, chooses the destination vectors and rings the doorbell with its own vector. The remote side takes its interrupt and clears it. In automatic-acknowledge mode, that clear turns the channel to acknowledged, and the sender's own vector line is raised. The sender removes the acknowledgement and gets back a ready channel. From a ready channel it can send again at once, or it can release the channel.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset the lock register (address 0xA00) reads 1, every channel's mode word reads 0x10 (idle, bit 4), and all interrupt outputs are 0.
- R2: While locked, writes to any channel register change nothing: the state, the message words and the interrupt outputs all keep their values.
- R3: Writing 0x1ACCE551 to address 0xA00 makes the lock read 0. Writing any other value there makes it read 1 again.
- R4: Each channel stores eight 32-bit message words at offsets 0x20 + 4*i of its window. Channel c's window starts at c*0x40. The words read back what was written, and the channels do not share storage.
- R5: Writing a one-hot vector to an idle channel's owner register (offset 0x00) claims it. The owner register reads that vector, and mode reads 0x20 (ready, bit 5) plus bit 0 for the acknowledge mode. A value that is not one-hot leaves the channel idle.
- R6: A non-zero owner write to a channel that is not idle is ignored. Writing 0 to the owner register returns any channel to idle and drops its pending destination and acknowledge interrupts.
- R7: On a ready channel, writing exactly the owner vector to the doorbell (offset 0x1C) ORs the destination selection (offset 0x04) into the pending bits and sets mode bit 6 (sent). Any other doorbell value, or a doorbell in another state, is ignored.
- R8: The pending-status register (offset 0x0C) reads the pending destination bits. Writing ones to the pending-clear register (offset 0x08) clears those bits.
- R9: Interrupt line v is high when some channel has pending bit v with mask bit v (offset 0x14) at 0, or when an acknowledged channel's owner vector has bit v. The mask resets to all ones.
- R10: With mode bit 0 set, a pending-clear that leaves a sent channel with no pending bits moves it to acknowledged. Mode then reads bit 7, and the owner's vector line goes high.
- R11: On an acknowledged channel, an acknowledge-clear write (offset 0x18) that has the owner bit returns the channel to ready and drops the owner line. A write without the owner bit is ignored.
- R12: With mode bit 0 clear, a pending-clear that empties a sent channel returns it directly to ready, with no acknowledge interrupt.
- R13: Addresses in a window beyond the last channel read 0 and accept no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_we_i | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address, combinational |
| irq_o | output | VEC_W | One interrupt line per vector, OR of all channels |

## Verification
A wrong channel state appears at the ports on the first edge after the write that caused it. The mode word is combinational on the address, and the interrupt lines come straight from registered state, so both show the error on the next read or the next sample. A stuck or skipped state shows as a wrong mode bit. It also shows as a destination line that fails to rise or an acknowledge line on the wrong vector. A lock that fails to hold shows only after unlocking, as a message word or mode word that changed when it should not have. The bench therefore reads those words back right after unlocking.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_READY = 2'd1,
      CH_SENT  = 2'd2,
      CH_ACKED = 2'd3
   } ch_state_e;

   // per-channel register offsets inside a 64-byte window
   localparam logic [5:0] OFS_OWNER = 6'h00;
   localparam logic [5:0] OFS_DSEL  = 6'h04;
   localparam logic [5:0] OFS_PCLR  = 6'h08;
   localparam logic [5:0] OFS_PSTAT = 6'h0C;
   localparam logic [5:0] OFS_MODE  = 6'h10;
   localparam logic [5:0] OFS_MASK  = 6'h14;
   localparam logic [5:0] OFS_ACLR  = 6'h18;
   localparam logic [5:0] OFS_BELL  = 6'h1C;
   localparam logic [5:0] OFS_WORD0 = 6'h20;

   localparam int          WIN_SHIFT  = 6;
   localparam int          MAX_WORDS  = 8;
   localparam logic [31:0] OPEN_KEY   = 32'h1ACC_E551;
   localparam logic [11:0] GUARD_ADDR = 12'hA00;

endpackage

// File: rtl/mbox_guard.sv
module mbox_guard
   import mbox_pkg::*;
#(
   parameter logic [31:0] KEY = OPEN_KEY
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        hit_i,
   input  logic [31:0] wdata_i,
   output logic        locked_o
);

   // R3: only the exact key opens the guard, anything else closes it
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         locked_o <= 1'b1;
      else if (hit_i)
         locked_o <= (wdata_i != KEY);
   end

endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
   import mbox_pkg::*;
#(
   parameter int VEC_W     = 8,
   parameter int NUM_WORDS = MAX_WORDS
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  logic [5:0]       ofs_i,
   input  logic [31:0]      wdata_i,
   output logic [31:0]      rdata_o,
   output logic [VEC_W-1:0] irq_o,
   output logic             idle_o,
   output logic             acked_o
);

   if (VEC_W < 1 || VEC_W > 32) begin : g_bad_vec
      $error("mbox_chan: VEC_W must be 1..32");
   end
   if (NUM_WORDS < 1 || NUM_WORDS > MAX_WORDS) begin : g_bad_words
      $error("mbox_chan: NUM_WORDS must be 1..8");
   end

   ch_state_e        state_q;
   logic [VEC_W-1:0] owner_q, dsel_q, pend_q, mask_q;
   logic             auto_q;
   logic [31:0]      word_q [NUM_WORDS];
   logic [VEC_W-1:0] wv, pend_left;

   assign wv        = wdata_i[VEC_W-1:0];
   assign pend_left = pend_q & ~wv;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= CH_IDLE;
         owner_q <= '0;
         dsel_q  <= '0;
         pend_q  <= '0;
         mask_q  <= '1;
         auto_q  <= 1'b0;
      end else if (we_i) begin
         unique case (ofs_i)
            OFS_OWNER: begin
               if (wv == '0) begin                          // R6 release
                  state_q <= CH_IDLE;
                  owner_q <= '0;
                  pend_q  <= '0;
               end else if (state_q == CH_IDLE && $onehot(wv)) begin // R5
                  state_q <= CH_READY;
                  owner_q <= wv;
               end
            end
            OFS_DSEL: dsel_q <= wv;
            OFS_PCLR: begin                                 // R8
               pend_q <= pend_left;
               if (state_q == CH_SENT && pend_left == '0)   // R10 / R12
                  state_q <= auto_q ? CH_ACKED : CH_READY;
            end
            OFS_MODE: auto_q <= wdata_i[0];
            OFS_MASK: mask_q <= wv;
            OFS_ACLR: begin                                 // R11
               if (state_q == CH_ACKED && (wv & owner_q) != '0)
                  state_q <= CH_READY;
            end
            OFS_BELL: begin                                 // R7
               if (state_q == CH_READY && wv == owner_q) begin
                  pend_q  <= pend_q | dsel_q;
                  state_q <= CH_SENT;
               end
            end
            default: ;
         endcase
      end
   end

   // R4: message words
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int w = 0; w < NUM_WORDS; w++) word_q[w] <= '0;
      end else if (we_i) begin
         for (int w = 0; w < NUM_WORDS; w++)
            if (ofs_i == OFS_WORD0 + 6'(4 * w)) word_q[w] <= wdata_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (ofs_i)
         OFS_OWNER: rdata_o[VEC_W-1:0] = owner_q;
         OFS_DSEL:  rdata_o[VEC_W-1:0] = dsel_q;
         OFS_PSTAT: rdata_o[VEC_W-1:0] = pend_q;
         OFS_MASK:  rdata_o[VEC_W-1:0] = mask_q;
         OFS_MODE:  rdata_o = {24'b0, state_q == CH_ACKED, state_q == CH_SENT,
                               state_q == CH_READY, state_q == CH_IDLE, 3'b0, auto_q};
         default: begin
            for (int w = 0; w < NUM_WORDS; w++)
               if (ofs_i == OFS_WORD0 + 6'(4 * w)) rdata_o = word_q[w];
         end
      endcase
   end

   // R9: unmasked pending destinations plus acknowledge on the owner vector
   assign irq_o   = (pend_q & ~mask_q) | ((state_q == CH_ACKED) ? owner_q : '0);
   assign idle_o  = (state_q == CH_IDLE);
   assign acked_o = (state_q == CH_ACKED);

endmodule

// File: rtl/mbox_irq_or.sv
module mbox_irq_or #(
   parameter int NUM_SRC = 4,
   parameter int W       = 8
) (
   input  logic [NUM_SRC-1:0][W-1:0] src_i,
   output logic [W-1:0]              irq_o
);

   always_comb begin
      irq_o = '0;
      for (int s = 0; s < NUM_SRC; s++) irq_o |= src_i[s];
   end

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
   import mbox_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int VEC_W     = 8,
   parameter int NUM_WORDS = MAX_WORDS,
   parameter int ADDR_W    = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic [VEC_W-1:0]  irq_o
);

   localparam int IDX_W = ADDR_W - WIN_SHIFT;

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
      $error("mbox_ctrl: NUM_CH must be 1..32");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("mbox_ctrl: ADDR_W must reach the guard register");
   end

   logic             lock_on, guard_hit, win_hit;
   logic [IDX_W-1:0] win_idx;
   logic [5:0]       win_ofs;
   logic [NUM_CH-1:0][31:0]      ch_rdata;
   logic [NUM_CH-1:0][VEC_W-1:0] ch_irq;
   logic [NUM_CH-1:0]            ch_idle, ch_acked;

   assign guard_hit = (bus_addr_i == ADDR_W'(GUARD_ADDR));
   assign win_idx   = bus_addr_i[ADDR_W-1:WIN_SHIFT];
   assign win_ofs   = bus_addr_i[WIN_SHIFT-1:0];
   assign win_hit   = ({1'b0, win_idx} < (IDX_W + 1)'(NUM_CH));   // R13

   mbox_guard u_guard (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (bus_we_i && guard_hit),
      .wdata_i  (bus_wdata_i),
      .locked_o (lock_on)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      mbox_chan #(.VEC_W(VEC_W), .NUM_WORDS(NUM_WORDS)) u_chan (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .we_i    (bus_we_i && !lock_on && win_hit && win_idx == IDX_W'(c)), // R2
         .ofs_i   (win_ofs),
         .wdata_i (bus_wdata_i),
         .rdata_o (ch_rdata[c]),
         .irq_o   (ch_irq[c]),
         .idle_o  (ch_idle[c]),
         .acked_o (ch_acked[c])
      );
   end

   always_comb begin
      bus_rdata_o = '0;
      if (guard_hit)
         bus_rdata_o = {31'b0, lock_on};
      else
         for (int c = 0; c < NUM_CH; c++)
            if (win_hit && win_idx == IDX_W'(c)) bus_rdata_o = ch_rdata[c];
   end

   mbox_irq_or #(.NUM_SRC(NUM_CH), .W(VEC_W)) u_irq (
      .src_i (ch_irq),
      .irq_o (irq_o)
   );

endmodule

// File: rtl/mbox_ctrl_chk.sv
module mbox_ctrl_chk
   import mbox_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 12
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic              bus_we_i,
   input logic [31:0]       bus_wdata_i,
   input logic [VEC_W-1:0]  irq_o,
   input logic              lock_on,
   input logic [NUM_CH-1:0] ch_idle,
   input logic [NUM_CH-1:0] ch_acked
);

   logic guard_wr;
   assign guard_wr = bus_we_i && bus_addr_i == ADDR_W'(GUARD_ADDR);

   p_key_opens_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (guard_wr && bus_wdata_i == OPEN_KEY) |=> !lock_on);

   p_other_closes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (guard_wr && bus_wdata_i != OPEN_KEY) |=> lock_on);

   p_locked_inert_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_on && bus_we_i && !guard_wr)
      |=> ($stable(irq_o) && $stable(ch_idle) && $stable(ch_acked)));

   p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&ch_idle) |-> (irq_o == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (bus_we_i && !lock_on && bus_addr_i == ADDR_W'(c * 64)
          && bus_wdata_i[VEC_W-1:0] == '0) |=> ch_idle[c]);

      p_ack_line_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ch_acked[c] |-> (irq_o != '0));
   end

endmodule

bind mbox_ctrl mbox_ctrl_chk #(.NUM_CH(NUM_CH), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_addr_i  (bus_addr_i),
   .bus_we_i    (bus_we_i),
   .bus_wdata_i (bus_wdata_i),
   .irq_o       (irq_o),
   .lock_on     (lock_on),
   .ch_idle     (ch_idle),
   .ch_acked    (ch_acked)
);

// File: tb/mbox_ctrl_test.sv
module mbox_ctrl_test;

   localparam int NCH = 4;
   localparam int NV  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NV-1:0] irq;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] exp_word [NCH][8];

   always #5 clk = ~clk;

   mbox_ctrl #(.NUM_CH(NCH), .VEC_W(NV), .ADDR_W(12)) uut (
      .clk_i (clk), .rst_ni (rst_n), .bus_addr_i (addr), .bus_we_i (we),
      .bus_wdata_i (wdata), .bus_rdata_o (rdata), .irq_o (irq)
   );

   function automatic logic [11:0] ca(input int ch, input int ofs);
      return 12'(ch * 64 + ofs);
   endfunction

   // expected mode word: 0 idle, 1 ready, 2 sent, 3 acked
   function automatic logic [31:0] mode_exp(input int st, input bit au);
      return (32'h10 << st) | {31'b0, au};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rchk("R1 lock", 12'hA00, 32'h1);
      for (int c = 0; c < NCH; c++) rchk("R1 mode", ca(c, 'h10), 32'h10);
      chk("R1 irq", 32'(irq), 32'h0);

      // R2 locked writes ignored
      wr(ca(0, 'h20), 32'h1234_5678);
      wr(ca(0, 'h00), 32'h1);
      rchk("R2 mode", ca(0, 'h10), 32'h10);

      // R3 lock sequence
      wr(12'hA00, 32'h1ACC_E551);
      rchk("R3 open", 12'hA00, 32'h0);
      wr(12'hA00, 32'hDEAD_BEEF);
      rchk("R3 close", 12'hA00, 32'h1);
      wr(ca(1, 'h24), 32'hFFFF_0000);
      wr(12'hA00, 32'h1ACC_E551);
      rchk("R3 reopen", 12'hA00, 32'h0);
      rchk("R2 word", ca(0, 'h20), 32'h0);
      rchk("R2 word2", ca(1, 'h24), 32'h0);
      rchk("R2 owner", ca(0, 'h00), 32'h0);

      // R4 message words, random contents
      for (int c = 0; c < NCH; c++)
         for (int w = 0; w < 8; w++) begin
            exp_word[c][w] = $urandom;
            wr(ca(c, 'h20 + 4 * w), exp_word[c][w]);
         end
      for (int c = 0; c < NCH; c++)
         for (int w = 0; w < 8; w++) rchk("R4 word", ca(c, 'h20 + 4 * w), exp_word[c][w]);

      // R13 window beyond the last channel
      wr(ca(NCH, 'h20), 32'hCAFE_F00D);
      rchk("R13 read", ca(NCH, 'h20), 32'h0);
      rchk("R13 mode", ca(NCH, 'h10), 32'h0);

      // R5 claim
      wr(ca(1, 'h00), 32'h04);
      rchk("R5 owner", ca(1, 'h00), 32'h04);
      rchk("R5 mode", ca(1, 'h10), mode_exp(1, 0));
      wr(ca(2, 'h00), 32'h06);
      rchk("R5 not onehot", ca(2, 'h00), 32'h0);
      rchk("R5 still idle", ca(2, 'h10), mode_exp(0, 0));

      // R6 claim of a busy channel ignored
      wr(ca(1, 'h00), 32'h08);
      rchk("R6 busy", ca(1, 'h00), 32'h04);

      // R7 doorbell on channel 1, automatic mode, destination vector 4
      wr(ca(1, 'h04), 32'h10);
      wr(ca(1, 'h14), ~32'h10);
      wr(ca(1, 'h10), 32'h1);
      rchk("R10 mode auto", ca(1, 'h10), mode_exp(1, 1));
      wr(ca(1, 'h1C), 32'h08);
      rchk("R7 wrong bell", ca(1, 'h10), mode_exp(1, 1));
      chk("R7 no irq", 32'(irq), 32'h0);
      wr(ca(1, 'h1C), 32'h04);
      rchk("R7 sent", ca(1, 'h10), mode_exp(2, 1));
      rchk("R8 status", ca(1, 'h0C), 32'h10);
      chk("R9 dest line", 32'(irq), 32'h10);

      // R9 mask on channel 3, manual mode, destination vector 6
      wr(ca(3, 'h00), 32'h01);
      wr(ca(3, 'h04), 32'h40);
      wr(ca(3, 'h1C), 32'h01);
      rchk("R8 status3", ca(3, 'h0C), 32'h40);
      chk("R9 masked", 32'(irq), 32'h10);
      wr(ca(3, 'h14), ~32'h40);
      chk("R9 unmasked", 32'(irq), 32'h50);

      // R10 automatic acknowledge
      wr(ca(1, 'h08), 32'h10);
      rchk("R8 cleared", ca(1, 'h0C), 32'h0);
      rchk("R10 acked", ca(1, 'h10), mode_exp(3, 1));
      chk("R10 ack line", 32'(irq), 32'h44);

      // R11 acknowledge clear
      wr(ca(1, 'h18), 32'h01);
      rchk("R11 wrong bit", ca(1, 'h10), mode_exp(3, 1));
      wr(ca(1, 'h18), 32'h04);
      rchk("R11 ready", ca(1, 'h10), mode_exp(1, 1));
      chk("R11 irq", 32'(irq), 32'h40);

      // R12 manual completion
      wr(ca(3, 'h08), 32'h40);
      rchk("R12 ready", ca(3, 'h10), mode_exp(1, 0));
      chk("R12 no ack", 32'(irq), 32'h0);

      // R7 resend straight from ready, then R6 release drops pending
      wr(ca(1, 'h1C), 32'h04);
      rchk("R7 resend", ca(1, 'h10), mode_exp(2, 1));
      chk("R7 resend irq", 32'(irq), 32'h10);
      wr(ca(1, 'h00), 32'h0);
      rchk("R6 release", ca(1, 'h10), mode_exp(0, 1));
      rchk("R6 pend", ca(1, 'h0C), 32'h0);
      chk("R6 irq", 32'(irq), 32'h0);
      wr(ca(3, 'h00), 32'h0);

      // random rounds through the full automatic cycle
      for (int r = 0; r < 24; r++) begin
         int c, s, d;
         c = $urandom_range(0, NCH - 1);
         s = $urandom_range(0, NV - 1);
         d = $urandom_range(0, NV - 1);
         wr(ca(c, 'h00), 32'(1) << s);
         wr(ca(c, 'h04), 32'(1) << d);
         wr(ca(c, 'h14), ~(32'(1) << d));
         wr(ca(c, 'h10), 32'h1);
         wr(ca(c, 'h1C), 32'(1) << s);
         chk("R9 rnd dest", 32'(irq), 32'(1) << d);
         wr(ca(c, 'h08), 32'(1) << d);
         rchk("R10 rnd acked", ca(c, 'h10), mode_exp(3, 1));
         chk("R10 rnd line", 32'(irq), 32'(1) << s);
         wr(ca(c, 'h18), 32'(1) << s);
         chk("R11 rnd clear", 32'(irq), 32'h0);
         wr(ca(c, 'h00), 32'h0);
         rchk("R6 rnd idle", ca(c, 'h10), mode_exp(0, 1));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule